// File: doc/BRIEF.md
# Dual Masked Alarm Comparator

This block watches a running BCD time of day and calendar and compares it against two alarm register sets. The comparison happens only on the once-per-second update strobe. Each alarm has its own sticky flag. A flag is set when the enabled fields of its alarm equal the current time, and it stays set until software clears it by writing a zero to it.

The first alarm compares seconds, minutes, hours and a day-or-date byte. The second alarm compares minutes, hours and a day-or-date byte, and it only fires when the seconds count is zero. The top bit of every alarm byte is a mask bit. A set mask bit drops that field from the comparison, so one alarm can repeat at a rate anywhere from every second up to once per calendar date.

A single active-low output pin has two modes:
- **Interrupt mode:** the pin is pulled low by any flag whose enable is set.
- **Wave mode:** the pin carries one of four square waves from an external divider, chosen by a two-bit rate field.

Top module: `alarm_irq_unit`

## Requirements
- R1: When no mask bit is set, alarm 1 sets its flag on a strobe only if seconds, minutes, hour and the selected day-or-date field all equal the alarm bytes. A mismatch in any single field leaves the flag clear.
- R2: Bit 7 of each alarm 1 byte masks that field. With all four mask bits set, the flag sets on every strobe. With only the seconds byte unmasked, the flag sets whenever the seconds match, whatever the minutes are.
- R3: Alarm 2 fires only when the seconds input is 0. With its three mask bits set, it fires once a minute at second 00 and not at second 01. With only the minutes unmasked, it needs the minutes to match as well.
- R4: In a day-or-date alarm byte, bit 6 = 1 compares bits 5:0 with the weekday (zero-extended), and bit 6 = 0 compares them with the date of the month.
- R5: The hour comparison uses the full 7-bit hour byte, including the 12/24 mode bit (bit 6) and the PM or tens bit (bit 5). A 24-hour clock value of 0x12 therefore does not match an alarm hour of 0x52.
- R6: Matches are evaluated only in a cycle with tick_i high. A matching time held without a strobe never sets a flag.
- R7: The flags are sticky, with two write rules:
  - A flag write with bit i = 0 clears flag i, and a written 1 leaves flag i unchanged.
  - If a match and a clearing write fall in the same cycle, the match wins.
- R8: Flags set on a match whatever the mode bit and the enable bits are.
- R9: In interrupt mode, int_sqw_no is low exactly when (flag1 AND enable1) OR (flag2 AND enable2). The control word is {a2 enable[4], a1 enable[3], interrupt mode[2], rate[1:0]}.
- R10: In wave mode (bit 2 = 0), int_sqw_no follows sqw_taps_i[rate]. The taps are ordered 0 = 1 Hz, 1 = 1.024 kHz, 2 = 4.096 kHz and 3 = 8.192 kHz.
- R11: After reset the flags are 0, the mode is interrupt, the rate is 3 and both enables are 0, so int_sqw_no stays high even after a flag sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Once-per-second update strobe |
| sec_i | input | 7 | Current seconds, BCD |
| min_i | input | 7 | Current minutes, BCD |
| hour_i | input | 7 | Current hour byte, raw incl. mode bits |
| wday_i | input | 3 | Day of week |
| mday_i | input | 6 | Date of month, BCD |
| a1_sec_i | input | 8 | Alarm 1 seconds, bit 7 mask |
| a1_min_i | input | 8 | Alarm 1 minutes, bit 7 mask |
| a1_hour_i | input | 8 | Alarm 1 hour, bit 7 mask |
| a1_dday_i | input | 8 | Alarm 1 day/date, bit 7 mask, bit 6 select |
| a2_min_i | input | 8 | Alarm 2 minutes, bit 7 mask |
| a2_hour_i | input | 8 | Alarm 2 hour, bit 7 mask |
| a2_dday_i | input | 8 | Alarm 2 day/date, bit 7 mask, bit 6 select |
| ctl_we_i | input | 1 | Control word write strobe |
| ctl_wdata_i | input | 5 | Control word {en2, en1, irq mode, rate} |
| flag_we_i | input | 1 | Flag write strobe |
| flag_wdata_i | input | 2 | Flag write data, 0 clears the flag |
| sqw_taps_i | input | 4 | Square waves from the external divider |
| alarm1_flag_o | output | 1 | Alarm 1 sticky flag |
| alarm2_flag_o | output | 1 | Alarm 2 sticky flag |
| int_sqw_no | output | 1 | Active-low interrupt or square-wave pin |

## Verification
The bench targets several corner cases, each tied to a specific wrong design:
- **Single-field mismatch:** a time equal to the alarm except in one field. A comparator that ignored that field would raise the flag.
- **Alarm 2 seconds gate:** alarm 2 fully masked at second 01. A design that forgot the implied zero-seconds term would fire every second.
- **Raw hour byte:** a 12-hour alarm hour against a 24-hour clock value. A design that compared only the numeric hour bits would report a false match.
- **Set versus clear:** a clearing write in the same cycle as a match. A design that gave the clear priority would lose the event.
- **Flag write polarity:** writing 1 to a flag. A design that treated 1 as the clear value would drop the flag.
- **Wave taps:** every rate code is driven with one-hot tap patterns. A swapped selector index would show on the pin.

// File: rtl/alarm_cmp_pkg.sv
package alarm_cmp_pkg;
  parameter int unsigned BYTE_W     = 8;
  parameter int unsigned FIELD_W    = BYTE_W - 1;
  parameter int unsigned WDAY_W     = 3;
  parameter int unsigned MDAY_W     = 6;
  parameter int unsigned NUM_ALARMS = 2;
  parameter int unsigned RATE_W     = 2;
  parameter int unsigned NUM_TAPS   = 1 << RATE_W;
  parameter int unsigned CTL_W      = RATE_W + 1 + NUM_ALARMS;

  localparam int unsigned MASK_BIT = BYTE_W - 1;
  localparam int unsigned SEL_BIT  = BYTE_W - 2;

  typedef struct packed {
    logic [FIELD_W-1:0] sec;
    logic [FIELD_W-1:0] min;
    logic [FIELD_W-1:0] hour;
    logic [WDAY_W-1:0]  wday;
    logic [MDAY_W-1:0]  mday;
  } tod_t;

  typedef struct packed {
    logic [BYTE_W-1:0] sec;
    logic [BYTE_W-1:0] min;
    logic [BYTE_W-1:0] hour;
    logic [BYTE_W-1:0] dday;
  } alarm_set_t;

  typedef struct packed {
    logic [NUM_ALARMS-1:0] en;
    logic                  irq_mode;
    logic [RATE_W-1:0]     rate;
  } ctl_t;

  localparam ctl_t CTL_RESET = '{en: '0, irq_mode: 1'b1, rate: '1};

  function automatic logic field_ok(logic [BYTE_W-1:0] alm, logic [FIELD_W-1:0] cur);
    return alm[MASK_BIT] | (alm[FIELD_W-1:0] == cur);
  endfunction
endpackage

// File: rtl/alarm_matcher.sv
module alarm_matcher
  import alarm_cmp_pkg::*;
(
  input  tod_t       tod_i,
  input  alarm_set_t alm_i,
  output logic       hit_o
);
  logic [MDAY_W-1:0] dd_ref;
  logic sec_ok, min_ok, hour_ok, dd_ok;

  always_comb begin
    dd_ref  = alm_i.dday[SEL_BIT] ? MDAY_W'(tod_i.wday) : tod_i.mday;
    dd_ok   = alm_i.dday[MASK_BIT] | (alm_i.dday[MDAY_W-1:0] == dd_ref);
    sec_ok  = field_ok(alm_i.sec, tod_i.sec);
    min_ok  = field_ok(alm_i.min, tod_i.min);
    // raw hour byte: mode and PM bits take part in the compare
    hour_ok = field_ok(alm_i.hour, tod_i.hour);
    hit_o   = sec_ok & min_ok & hour_ok & dd_ok;
  end
endmodule

// File: rtl/alarm_flag.sv
module alarm_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic hit_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              flag_o <= 1'b0;
    else if (tick_i && hit_i) flag_o <= 1'b1;  // set beats clear
    else if (clr_i)           flag_o <= 1'b0;
  end
endmodule

// File: rtl/alarm_ctl_reg.sv
module alarm_ctl_reg
  import alarm_cmp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CTL_W-1:0] wdata_i,
  output ctl_t             ctl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctl_o <= CTL_RESET;
    else if (we_i) ctl_o <= ctl_t'(wdata_i);
  end
endmodule

// File: rtl/alarm_pin_mux.sv
module alarm_pin_mux
  import alarm_cmp_pkg::*;
(
  input  logic [NUM_ALARMS-1:0] flags_i,
  input  ctl_t                  ctl_i,
  input  logic [NUM_TAPS-1:0]   taps_i,
  output logic                  pin_no
);
  always_comb begin
    if (ctl_i.irq_mode) pin_no = ~|(flags_i & ctl_i.en);
    else                pin_no = taps_i[ctl_i.rate];
  end
endmodule

// File: rtl/alarm_irq_unit.sv
module alarm_irq_unit
  import alarm_cmp_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  tick_i,
  input  logic [FIELD_W-1:0]    sec_i,
  input  logic [FIELD_W-1:0]    min_i,
  input  logic [FIELD_W-1:0]    hour_i,
  input  logic [WDAY_W-1:0]     wday_i,
  input  logic [MDAY_W-1:0]     mday_i,
  input  logic [BYTE_W-1:0]     a1_sec_i,
  input  logic [BYTE_W-1:0]     a1_min_i,
  input  logic [BYTE_W-1:0]     a1_hour_i,
  input  logic [BYTE_W-1:0]     a1_dday_i,
  input  logic [BYTE_W-1:0]     a2_min_i,
  input  logic [BYTE_W-1:0]     a2_hour_i,
  input  logic [BYTE_W-1:0]     a2_dday_i,
  input  logic                  ctl_we_i,
  input  logic [CTL_W-1:0]      ctl_wdata_i,
  input  logic                  flag_we_i,
  input  logic [NUM_ALARMS-1:0] flag_wdata_i,
  input  logic [NUM_TAPS-1:0]   sqw_taps_i,
  output logic                  alarm1_flag_o,
  output logic                  alarm2_flag_o,
  output logic                  int_sqw_no
);
  tod_t                  tod;
  alarm_set_t            alm [NUM_ALARMS];
  logic [NUM_ALARMS-1:0] hit;
  logic [NUM_ALARMS-1:0] flags;
  ctl_t                  ctl;

  assign tod = '{sec: sec_i, min: min_i, hour: hour_i, wday: wday_i, mday: mday_i};

  // alarm 2 has no seconds byte: an unmasked zero pins it to second 00
  assign alm[0] = '{sec: a1_sec_i, min: a1_min_i, hour: a1_hour_i, dday: a1_dday_i};
  assign alm[1] = '{sec: '0,       min: a2_min_i, hour: a2_hour_i, dday: a2_dday_i};

  for (genvar g = 0; g < NUM_ALARMS; g++) begin : g_alarm
    alarm_matcher u_match (
      .tod_i (tod),
      .alm_i (alm[g]),
      .hit_o (hit[g])
    );
    alarm_flag u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (tick_i),
      .hit_i  (hit[g]),
      .clr_i  (flag_we_i & ~flag_wdata_i[g]),
      .flag_o (flags[g])
    );
  end

  alarm_ctl_reg u_ctl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ctl_we_i),
    .wdata_i (ctl_wdata_i),
    .ctl_o   (ctl)
  );

  alarm_pin_mux u_pin (
    .flags_i (flags),
    .ctl_i   (ctl),
    .taps_i  (sqw_taps_i),
    .pin_no  (int_sqw_no)
  );

  assign alarm1_flag_o = flags[0];
  assign alarm2_flag_o = flags[1];
endmodule

// File: rtl/alarm_irq_unit_chk.sv
module alarm_irq_unit_chk
  import alarm_cmp_pkg::*;
(
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  tick_i,
  input logic [FIELD_W-1:0]    sec_i,
  input logic                  flag_we_i,
  input logic [NUM_ALARMS-1:0] flag_wdata_i,
  input logic [NUM_ALARMS-1:0] hit_i,
  input logic                  alarm1_flag_o,
  input logic                  alarm2_flag_o
);
  assert_set_on_hit_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && hit_i[0]) |=> alarm1_flag_o);

  assert_a2_zero_sec_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i[1] |-> (sec_i == '0));

  assert_no_set_without_tick_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !alarm1_flag_o && !alarm2_flag_o) |=> (!alarm1_flag_o && !alarm2_flag_o));

  assert_clear_on_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && !flag_wdata_i[0] && !(tick_i && hit_i[0])) |=> !alarm1_flag_o);

  assert_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alarm2_flag_o && !(flag_we_i && !flag_wdata_i[1])) |=> alarm2_flag_o);

  assert_set_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && hit_i[1] && flag_we_i && !flag_wdata_i[1]) |=> alarm2_flag_o);
endmodule

bind alarm_irq_unit alarm_irq_unit_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .tick_i        (tick_i),
  .sec_i         (sec_i),
  .flag_we_i     (flag_we_i),
  .flag_wdata_i  (flag_wdata_i),
  .hit_i         (hit),
  .alarm1_flag_o (alarm1_flag_o),
  .alarm2_flag_o (alarm2_flag_o)
);

// File: tb/alarm_irq_unit_test.sv
`timescale 1ns/1ps
module alarm_irq_unit_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic [6:0] sec_i = '0, min_i = '0, hour_i = '0;
  logic [2:0] wday_i = '0;
  logic [5:0] mday_i = '0;
  logic [7:0] a1_sec_i = '0, a1_min_i = '0, a1_hour_i = '0, a1_dday_i = '0;
  logic [7:0] a2_min_i = '0, a2_hour_i = '0, a2_dday_i = '0;
  logic       ctl_we_i = 1'b0;
  logic [4:0] ctl_wdata_i = '0;
  logic       flag_we_i = 1'b0;
  logic [1:0] flag_wdata_i = '0;
  logic [3:0] sqw_taps_i = '0;
  logic       alarm1_flag_o, alarm2_flag_o, int_sqw_no;

  int checks = 0;
  int errors = 0;

  always #2 clk_i = ~clk_i;

  alarm_irq_unit uut (.*);

  task automatic check(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, got, exp);
    end
  endtask

  task automatic set_time(input logic [6:0] s, input logic [6:0] m, input logic [6:0] h,
                          input logic [2:0] wd, input logic [5:0] md);
    @(negedge clk_i);
    sec_i = s; min_i = m; hour_i = h; wday_i = wd; mday_i = md;
  endtask

  task automatic pulse_tick();
    @(negedge clk_i) tick_i = 1'b1;
    @(negedge clk_i) tick_i = 1'b0;
  endtask

  task automatic clear_flags();
    @(negedge clk_i) begin flag_we_i = 1'b1; flag_wdata_i = 2'b00; end
    @(negedge clk_i) flag_we_i = 1'b0;
  endtask

  task automatic write_ctl(input logic [4:0] w);
    @(negedge clk_i) begin ctl_we_i = 1'b1; ctl_wdata_i = w; end
    @(negedge clk_i) ctl_we_i = 1'b0;
  endtask

  task automatic set_a1(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h, input logic [7:0] d);
    @(negedge clk_i);
    a1_sec_i = s; a1_min_i = m; a1_hour_i = h; a1_dday_i = d;
  endtask

  task automatic set_a2(input logic [7:0] m, input logic [7:0] h, input logic [7:0] d);
    @(negedge clk_i);
    a2_min_i = m; a2_hour_i = h; a2_dday_i = d;
  endtask

  task automatic t_reset();
    sqw_taps_i = 4'b0111;  // tap 3 low: wave mode would pull the pin low
    @(negedge clk_i);
    check(alarm1_flag_o, 1'b0, "R11 flag1 after reset");
    check(alarm2_flag_o, 1'b0, "R11 flag2 after reset");
    check(int_sqw_no, 1'b1, "R11 pin high after reset");
    set_a1(8'h80, 8'h80, 8'h80, 8'h80);
    set_time(7'h00, 7'h00, 7'h00, 3'd1, 6'h01);
    pulse_tick();
    check(alarm1_flag_o, 1'b1, "R11 flag sets");
    check(int_sqw_no, 1'b1, "R11 enables off after reset");
    clear_flags();
  endtask

  task automatic t_full_match();
    set_a1(8'h56, 8'h34, 8'h12, 8'h15);
    set_time(7'h55, 7'h34, 7'h12, 3'd2, 6'h15);
    pulse_tick();
    check(alarm1_flag_o, 1'b0, "R1 seconds differ");
    set_time(7'h56, 7'h34, 7'h12, 3'd2, 6'h16);
    pulse_tick();
    check(alarm1_flag_o, 1'b0, "R1 date differs");
    set_time(7'h56, 7'h35, 7'h12, 3'd2, 6'h15);
    pulse_tick();
    check(alarm1_flag_o, 1'b0, "R1 minutes differ");
    set_time(7'h56, 7'h34, 7'h12, 3'd2, 6'h15);
    pulse_tick();
    check(alarm1_flag_o, 1'b1, "R1 full match");
    clear_flags();
  endtask

  task automatic t_masks_a1();
    set_a1(8'h80, 8'h80, 8'h80, 8'h80);
    set_time(7'h17, 7'h42, 7'h09, 3'd5, 6'h28);
    pulse_tick();
    check(alarm1_flag_o, 1'b1, "R2 all masked fires");
    clear_flags();
    set_a1(8'h30, 8'h80, 8'h80, 8'h80);
    set_time(7'h29, 7'h11, 7'h09, 3'd5, 6'h28);
    pulse_tick();
    check(alarm1_flag_o, 1'b0, "R2 seconds only, mismatch");
    set_time(7'h30, 7'h59, 7'h09, 3'd5, 6'h28);
    pulse_tick();
    check(alarm1_flag_o, 1'b1, "R2 seconds only, match");
    clear_flags();
  endtask

  task automatic t_alarm2();
    set_a2(8'h80, 8'h80, 8'h80);
    set_time(7'h01, 7'h10, 7'h08, 3'd3, 6'h05);
    pulse_tick();
    check(alarm2_flag_o, 1'b0, "R3 masked, second 01");
    set_time(7'h00, 7'h11, 7'h08, 3'd3, 6'h05);
    pulse_tick();
    check(alarm2_flag_o, 1'b1, "R3 masked, second 00");
    clear_flags();
    set_a2(8'h45, 8'h80, 8'h80);
    set_time(7'h00, 7'h44, 7'h08, 3'd3, 6'h05);
    pulse_tick();
    check(alarm2_flag_o, 1'b0, "R3 minutes mismatch");
    set_time(7'h00, 7'h45, 7'h08, 3'd3, 6'h05);
    pulse_tick();
    check(alarm2_flag_o, 1'b1, "R3 minutes match");
    clear_flags();
  endtask

  task automatic t_day_date();
    set_a1(8'h80, 8'h80, 8'h80, 8'h44);  // weekday 4
    set_time(7'h00, 7'h00, 7'h00, 3'd3, 6'h04);
    pulse_tick();
    check(alarm1_flag_o, 1'b0, "R4 weekday select ignores date");
    set_time(7'h00, 7'h00, 7'h00, 3'd4, 6'h21);
    pulse_tick();
    check(alarm1_flag_o, 1'b1, "R4 weekday match");
    clear_flags();
    set_a1(8'h80, 8'h80, 8'h80, 8'h04);  // date 04
    set_time(7'h00, 7'h00, 7'h00, 3'd4, 6'h21);
    pulse_tick();
    check(alarm1_flag_o, 1'b0, "R4 date select ignores weekday");
    set_time(7'h00, 7'h00, 7'h00, 3'd1, 6'h04);
    pulse_tick();
    check(alarm1_flag_o, 1'b1, "R4 date match");
    clear_flags();
  endtask

  task automatic t_hour_raw();
    set_a1(8'h80, 8'h80, 8'h52, 8'h80);  // 12 h mode, 12 AM
    set_time(7'h00, 7'h00, 7'h12, 3'd1, 6'h01);
    pulse_tick();
    check(alarm1_flag_o, 1'b0, "R5 24h 12 vs 12h alarm");
    set_time(7'h00, 7'h00, 7'h72, 3'd1, 6'h01);
    pulse_tick();
    check(alarm1_flag_o, 1'b0, "R5 PM bit differs");
    set_time(7'h00, 7'h00, 7'h52, 3'd1, 6'h01);
    pulse_tick();
    check(alarm1_flag_o, 1'b1, "R5 raw byte match");
    clear_flags();
  endtask

  task automatic t_tick_only();
    set_a1(8'h80, 8'h80, 8'h80, 8'h80);
    set_time(7'h05, 7'h00, 7'h00, 3'd1, 6'h01);
    repeat (4) @(negedge clk_i);
    check(alarm1_flag_o, 1'b0, "R6 no strobe no flag");
    set_time(7'h06, 7'h00, 7'h00, 3'd1, 6'h01);
    @(negedge clk_i);
    check(alarm1_flag_o, 1'b0, "R6 time change without strobe");
  endtask

  task automatic t_clear();
    set_a1(8'h80, 8'h80, 8'h80, 8'h80);
    set_a2(8'h80, 8'h80, 8'h80);
    set_time(7'h00, 7'h00, 7'h00, 3'd1, 6'h01);
    pulse_tick();
    check(alarm2_flag_o, 1'b1, "R7 flag2 set");
    @(negedge clk_i) begin flag_we_i = 1'b1; flag_wdata_i = 2'b11; end
    @(negedge clk_i) flag_we_i = 1'b0;
    check(alarm1_flag_o, 1'b1, "R7 write 1 keeps flag1");
    check(alarm2_flag_o, 1'b1, "R7 write 1 keeps flag2");
    @(negedge clk_i) begin flag_we_i = 1'b1; flag_wdata_i = 2'b10; end
    @(negedge clk_i) flag_we_i = 1'b0;
    check(alarm1_flag_o, 1'b0, "R7 write 0 clears flag1");
    check(alarm2_flag_o, 1'b1, "R7 flag2 untouched");
    @(negedge clk_i) begin flag_we_i = 1'b1; flag_wdata_i = 2'b00; tick_i = 1'b1; end
    @(negedge clk_i) begin flag_we_i = 1'b0; tick_i = 1'b0; end
    check(alarm1_flag_o, 1'b1, "R7 set wins over clear");
    check(alarm2_flag_o, 1'b1, "R7 set wins over clear 2");
    clear_flags();
    check(alarm2_flag_o, 1'b0, "R7 cleared");
  endtask

  task automatic t_flag_indep();
    write_ctl(5'b00_0_10);  // wave mode, no enables
    set_a1(8'h80, 8'h80, 8'h80, 8'h80);
    pulse_tick();
    check(alarm1_flag_o, 1'b1, "R8 flag sets in wave mode");
    clear_flags();
  endtask

  task automatic t_irq_pin();
    write_ctl(5'b01_1_11);  // interrupt mode, a1 enable only
    sqw_taps_i = 4'b0000;
    set_a1(8'h80, 8'h80, 8'h80, 8'h80);
    set_a2(8'h80, 8'h80, 8'h80);
    set_time(7'h00, 7'h00, 7'h00, 3'd1, 6'h01);
    check(int_sqw_no, 1'b1, "R9 idle high");
    pulse_tick();
    check(int_sqw_no, 1'b0, "R9 flag1 enabled asserts");
    @(negedge clk_i) begin flag_we_i = 1'b1; flag_wdata_i = 2'b10; end
    @(negedge clk_i) flag_we_i = 1'b0;
    check(alarm2_flag_o, 1'b1, "R9 flag2 still set");
    check(int_sqw_no, 1'b1, "R9 flag2 without enable");
    write_ctl(5'b10_1_11);
    check(int_sqw_no, 1'b0, "R9 flag2 enabled asserts");
    clear_flags();
    check(int_sqw_no, 1'b1, "R9 released after clear");
  endtask

  task automatic t_wave();
    for (int r = 0; r < 4; r++) begin
      write_ctl({2'b11, 1'b0, 2'(r)});
      for (int p = 0; p < 4; p++) begin
        @(negedge clk_i) sqw_taps_i = 4'(1 << p);
        @(negedge clk_i);
        check(int_sqw_no, logic'(p == r), $sformatf("R10 rate %0d tap %0d", r, p));
      end
      @(negedge clk_i) sqw_taps_i = ~4'(1 << r);
      @(negedge clk_i);
      check(int_sqw_no, 1'b0, $sformatf("R10 rate %0d inverted", r));
    end
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_full_match();
    t_masks_a1();
    t_alarm2();
    t_day_date();
    t_hour_raw();
    t_tick_only();
    t_clear();
    t_flag_indep();
    t_irq_pin();
    t_wave();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule